// File: doc/BRIEF.md
# Strobed Configuration Register Port with Routing Matrix

This block is the device side of a narrow parallel configuration bus. The host drives one 8-bit word. The top bit is a strobe, and the lower seven bits carry either a register address or a data value. The block synchronises the strobe and detects its rising edge. On that edge it captures the low seven bits. The range of the captured value decides how it is used: a value with bit 6 set selects one of 64 six-bit registers, and a value with bit 6 clear is data for the register already selected.

The block reads back the selected register continuously. Four of the registers build up a routing link:
- Registers 0 and 1 hold the upper and lower halves of a 12-bit destination ID.
- Registers 2 and 3 hold the upper and lower halves of a 12-bit source ID.

Writing register 3 commits the link. The routing-matrix entry of the assembled destination then takes the assembled source. Each destination therefore names exactly one source, and a source may feed many destinations. The matrix is presented as a flat vector that the audio path downstream decodes.

Top module: `cfg_route_port`

## Requirements
- R1: After reset every register holds 0, no register is selected, `bus_rd` is 0 and every matrix entry is source 0.
- R2: A capture happens only on a 0-to-1 transition of `bus_in[7]`, seen through a two-flop synchroniser. Changing `bus_in[6:0]` while the strobe stays high captures nothing further.
- R3: A captured value from 0x40 to 0x7F selects register (value - 0x40), and the selection persists until the next select.
- R4: A captured value from 0x00 to 0x3F is written into the selected register. While a register is selected, `bus_rd[14:8]` shows its content zero-extended to 7 bits, and every other bit of `bus_rd` is 0.
- R5: Data captured before any select has no effect, and `bus_rd` stays 0 until a select arrives.
- R6: A data write to register 3 sets matrix entry D to S. D is {reg0, reg1} and S is {reg2, written value}, six bits each, with the upper half first. Entry D sits at `route_map[D*12 +: 12]`.
- R7: Writes to any register other than 3, and register selects, leave the matrix unchanged.
- R8: A commit whose destination D is NUM_DST or more leaves the matrix unchanged.
- R9: Several destinations may hold the same source, and a later commit to a destination replaces its earlier source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_in | input | 8 | Host word: bit 7 is the strobe, bits 6:0 are the select or data value |
| bus_rd | output | 16 | Readback word, with the selected register in bits 14:8 |
| route_map | output | NUM_DST*12 | Flat routing matrix, one 12-bit source per destination |

## Verification
The bench checks the following corner cases, and each one would show up as a specific fault:
- **Strobe held high while the value bits change.** An edge detector that was level-sensitive would overwrite the register with the second value.
- **Data sent straight after reset, before any select.** A design that fell back to register 0 would leak the value into the readback.
- **Partial link sequences.** A commit tied to the wrong register would move the matrix early.
- **Destination IDs just past the matrix.** A truncated index would alias these onto a low entry.
- **One source fanned out to several destinations, then one destination overwritten.** Shared or stale state between entries would appear here.

Random host traffic, compared against a bench model after every strobe, covers the remaining select and data interleavings.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;
  localparam int VAL_W   = 7;
  localparam int FIELD_W = 6;
  localparam int NREG    = 64;
  localparam int IDX_W   = $clog2(NREG);
  localparam int ID_W    = 2 * FIELD_W;
  localparam int RD_W    = 16;
  localparam int RD_LSB  = 8;

  // a captured value with its top bit set addresses a register
  function automatic logic is_select(input logic [VAL_W-1:0] v);
    return v[VAL_W-1];
  endfunction

  // register number is the value minus the select base
  function automatic logic [IDX_W-1:0] sel_of(input logic [VAL_W-1:0] v);
    return v[IDX_W-1:0];
  endfunction

  function automatic logic [ID_W-1:0] join_id(input logic [FIELD_W-1:0] hi,
                                              input logic [FIELD_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [RD_W-1:0] pack_rd(input logic valid,
                                              input logic [FIELD_W-1:0] r);
    logic [RD_W-1:0] w;
    w = '0;
    if (valid) w[RD_LSB +: FIELD_W] = r;
    return w;
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_in,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= strobe_in;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
  import cfg_route_pkg::*;
#(
  parameter int COMMIT_REG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic [VAL_W-1:0]  cap_val,
  output logic              sel_valid,
  output logic [IDX_W-1:0]  sel_idx,
  output logic [FIELD_W-1:0] rd_data,
  output logic              commit,
  output logic [ID_W-1:0]   commit_dst,
  output logic [ID_W-1:0]   commit_src
);
  logic [FIELD_W-1:0] regs [NREG];
  logic               wr_evt;
  logic               sel_evt;

  assign sel_evt = rise &  is_select(cap_val);
  assign wr_evt  = rise & ~is_select(cap_val) & sel_valid;
  assign commit  = wr_evt & (sel_idx == IDX_W'(COMMIT_REG));

  assign commit_dst = join_id(regs[0], regs[1]);
  assign commit_src = join_id(regs[2], cap_val[FIELD_W-1:0]);
  assign rd_data    = regs[sel_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid <= 1'b0;
      sel_idx   <= '0;
    end else if (sel_evt) begin
      sel_valid <= 1'b1;
      sel_idx   <= sel_of(cap_val);
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[r] <= '0;
      else if (wr_evt && sel_idx == IDX_W'(r))
        regs[r] <= cap_val[FIELD_W-1:0];
    end
  end
endmodule

// File: rtl/route_matrix.sv
module route_matrix
  import cfg_route_pkg::*;
#(
  parameter int NUM_DST = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    commit,
  input  logic [ID_W-1:0]         dst,
  input  logic [ID_W-1:0]         src,
  output logic [NUM_DST*ID_W-1:0] map_flat
);
  for (genvar d = 0; d < NUM_DST; d++) begin : g_entry
    logic hit;
    assign hit = commit & (dst == ID_W'(d));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   map_flat[d*ID_W +: ID_W] <= '0;
      else if (hit) map_flat[d*ID_W +: ID_W] <= src;
    end
  end
endmodule

// File: rtl/cfg_route_port.sv
module cfg_route_port
  import cfg_route_pkg::*;
#(
  parameter int NUM_DST     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              bus_in,
  output logic [RD_W-1:0]         bus_rd,
  output logic [NUM_DST*ID_W-1:0] route_map
);
  logic               strobe_rise;
  logic [VAL_W-1:0]   cap_val;
  logic               sel_valid;
  logic [IDX_W-1:0]   sel_idx;
  logic [FIELD_W-1:0] rd_data;
  logic               commit_evt;
  logic [ID_W-1:0]    commit_dst;
  logic [ID_W-1:0]    commit_src;

  assign cap_val = bus_in[VAL_W-1:0];

  strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_in(bus_in[7]), .rise(strobe_rise)
  );

  cfg_reg_file #(.COMMIT_REG(3)) u_regs (
    .clk(clk), .rst_n(rst_n), .rise(strobe_rise), .cap_val(cap_val),
    .sel_valid(sel_valid), .sel_idx(sel_idx), .rd_data(rd_data),
    .commit(commit_evt), .commit_dst(commit_dst), .commit_src(commit_src)
  );

  route_matrix #(.NUM_DST(NUM_DST)) u_matrix (
    .clk(clk), .rst_n(rst_n), .commit(commit_evt), .dst(commit_dst),
    .src(commit_src), .map_flat(route_map)
  );

  assign bus_rd = pack_rd(sel_valid, rd_data);
endmodule

// File: rtl/cfg_route_chk.sv
module cfg_route_chk
  import cfg_route_pkg::*;
#(
  parameter int NUM_DST = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    strobe_rise,
  input logic [VAL_W-1:0]        cap_val,
  input logic                    sel_valid,
  input logic [IDX_W-1:0]        sel_idx,
  input logic                    commit_evt,
  input logic [RD_W-1:0]         bus_rd,
  input logic [NUM_DST*ID_W-1:0] route_map
);
  AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise |=> !strobe_rise); // R2

  AST_SELECT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_rise && cap_val[6]) |=> (sel_valid && sel_idx == $past(cap_val[5:0]))); // R3

  AST_RD_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd[15:14] == 2'b00 && bus_rd[7:0] == 8'h00)); // R4

  AST_UNSELECTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (bus_rd == '0)); // R5

  AST_EARLY_DATA_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_rise && !cap_val[6] && !sel_valid) |=> (!sel_valid && $stable(route_map))); // R5

  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(route_map)); // R7

  AST_COMMIT_ON_REG3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> (sel_valid && sel_idx == 6'd3 && strobe_rise)); // R6
endmodule

bind cfg_route_port cfg_route_chk #(.NUM_DST(NUM_DST)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe_rise(strobe_rise), .cap_val(cap_val),
  .sel_valid(sel_valid), .sel_idx(sel_idx), .commit_evt(commit_evt),
  .bus_rd(bus_rd), .route_map(route_map)
);

// File: tb/tb_cfg_route_port.sv
module tb_cfg_route_port;
  localparam int NDST = 16;
  localparam int IW   = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       bus_in = 8'h00;
  logic [15:0]      bus_rd;
  logic [NDST*IW-1:0] route_map;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model
  logic [5:0]  m_regs [64];
  logic [5:0]  m_sel;
  bit          m_valid;
  logic [11:0] m_map [NDST];

  always #10 clk = ~clk; // 50 MHz

  cfg_route_port #(.NUM_DST(NDST)) dut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_rd(bus_rd), .route_map(route_map)
  );

  function automatic logic [15:0] exp_rd();
    logic [15:0] e;
    e = 16'h0000;
    if (m_valid) e = 16'(m_regs[m_sel]) << 8;
    return e;
  endfunction

  function automatic logic [NDST*IW-1:0] exp_map();
    logic [NDST*IW-1:0] e;
    for (int d = 0; d < NDST; d++) e[d*IW +: IW] = m_map[d];
    return e;
  endfunction

  task automatic model_apply(input logic [6:0] v);
    int dst;
    if (v >= 7'h40) begin
      m_sel = 6'(v - 7'h40);
      m_valid = 1;
    end else if (m_valid) begin
      m_regs[m_sel] = v[5:0];
      if (m_sel == 6'd3) begin
        dst = m_regs[0] * 64 + m_regs[1];
        if (dst < NDST) m_map[dst] = {m_regs[2], v[5:0]};
      end
    end
  endtask

  task automatic send(input logic [6:0] v);
    @(negedge clk) bus_in = {1'b1, v};
    repeat (4) @(negedge clk);
    bus_in = {1'b0, v};
    repeat (4) @(negedge clk);
    model_apply(v);
  endtask

  task automatic chk_rd(input string tag);
    checks++;
    if (bus_rd !== exp_rd()) begin
      fails++;
      $display("FAIL %s: bus_rd actual=%h expected=%h", tag, bus_rd, exp_rd());
    end
  endtask

  task automatic chk_map(input string tag);
    checks++;
    if (route_map !== exp_map()) begin
      fails++;
      $display("FAIL %s: route_map actual=%h expected=%h", tag, route_map, exp_map());
    end
  endtask

  task automatic link(input logic [11:0] dst, input logic [11:0] src);
    send(7'h40); send({1'b0, dst[11:6]});
    send(7'h41); send({1'b0, dst[5:0]});
    send(7'h42); send({1'b0, src[11:6]});
    send(7'h43); send({1'b0, src[5:0]});
  endtask

  initial begin
    for (int i = 0; i < 64; i++) m_regs[i] = '0;
    for (int d = 0; d < NDST; d++) m_map[d] = '0;
    m_sel = '0; m_valid = 0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_rd("R1 reset readback");
    chk_map("R1 reset matrix");

    // R5: data before any select
    send(7'h15);
    chk_rd("R5 early data readback");
    send(7'h40);
    chk_rd("R5 reg0 untouched by early data");

    // R4/R3 writes and boundary register
    send(7'h2A);
    chk_rd("R4 write reg0");
    send(7'h7F); send(7'h3F);
    chk_rd("R3 select reg63 write");
    send(7'h40);
    chk_rd("R3 reselect reg0 holds");

    // R2 held strobe with changing value bits
    send(7'h45);
    @(negedge clk) bus_in = 8'h91;
    repeat (4) @(negedge clk);
    bus_in = 8'hA2;
    repeat (4) @(negedge clk);
    bus_in = 8'h22;
    repeat (4) @(negedge clk);
    model_apply(7'h11);
    chk_rd("R2 held strobe single capture");

    // R7 partial sequence then R6 commit
    send(7'h40); send(7'h00);
    send(7'h41); send(7'h03);
    send(7'h42); send(7'h00);
    chk_map("R7 partial link no change");
    send(7'h43); send(7'h09);
    chk_map("R6 commit dst3");
    checks++;
    if (route_map[3*IW +: IW] !== 12'h009) begin
      fails++;
      $display("FAIL R6 entry3 actual=%h expected=%h", route_map[3*IW +: IW], 12'h009);
    end

    // R9 fan-out and replace
    link(12'd7, 12'h009);
    chk_map("R9 fan-out same source");
    link(12'd3, 12'hFFF);
    chk_map("R9 replace source");

    // R8 out-of-range destinations
    link(12'h040, 12'h123);
    chk_map("R8 dst 0x40 ignored");
    link(12'd16, 12'h456);
    chk_map("R8 dst 16 ignored");
    link(12'd15, 12'h789);
    chk_map("R6 last entry");

    // R7 other register writes
    send(7'h44); send(7'h1F);
    send(7'h41); send(7'h02);
    chk_map("R7 non-commit writes");

    // random traffic
    for (int n = 0; n < 300; n++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 2)
        link(12'($urandom_range(0, NDST + 2)), 12'($urandom));
      else
        send(7'($urandom));
      chk_rd("R4 random readback");
      chk_map("R6 random matrix");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule